// File: doc/BRIEF.md
# Branch record ring buffer

This block keeps a short history of taken control-flow transfers. Each accepted branch event from the retire stage is stored as a pair of 64-bit words: a source word that also carries the mispredict, in-transaction and abort flags, and a target word that also carries the number of cycles since the previous recording. The entries sit in a circular store of `DEPTH` slots. A top-of-stack (TOS) pointer always names the newest entry, so the entry `i` places back is found at `(TOS - i) mod DEPTH`.

A 10-bit select word controls what is captured. Bits 0 to 8 work in suppress mode: a set bit blocks a class of branches. Bit 9 is active-high and turns the buffer into a call stack. In that mode calls push an entry and near returns pop one. Recording also depends on a global enable and can be frozen by a performance-interrupt pulse. Freezing is not applied while call-stack mode is active, because interrupt-path calls and returns would corrupt the pointer.

Software reads any entry through an index port. It can overwrite an entry or the TOS pointer through a write port, and such a write has priority over a capture in the same cycle.

Top module: `brr_ring`

## Requirements
- R1: After reset the TOS pointer is 0, the freeze flag is 0, and every source and target word reads as zero, which means "not yet filled".
- R2: In normal mode (select bit 9 clear), an accepted branch advances TOS by one modulo DEPTH and writes its words at the new TOS. Reading index (TOS - i) mod DEPTH returns the i-th previous recorded branch.
- R3: Layout of the source word: bit 63 is the mispredict flag, bit 62 the in-transaction flag, bit 61 the abort flag, and bits 60:0 the source address sign-extended from ADDR_W bits.
- R4: In the timed variant the target word holds, in bits 63:48, the number of clock cycles since the previous recording, saturating at 65535, and holds the target address in bits 47:0.
- R5: Select bits 2 to 8 suppress the branch categories coded 0 to 6 on `br_cat_i`: 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch. Category code 7 is never recorded.
- R6: The privilege filter is judged on the target ring `br_ring_i`. Select bit 0 suppresses a target at ring 0, and select bit 1 suppresses a target at any ring above 0.
- R7: With select bit 9 set, an accepted relative or indirect call pushes as in R2, and an accepted near return moves TOS back by one and leaves the entries unchanged. Other categories are not recorded. The suppress bits still apply.
- R8: With freeze-on-interrupt enabled and call-stack mode off, a `pmi_i` pulse sets the freeze flag from the next cycle onward. A branch in the pulse cycle is still recorded. While the flag is set nothing is recorded. `frz_clr_i` clears the flag, but a pulse in the same cycle wins.
- R9: While select bit 9 is set, `pmi_i` never sets the freeze flag.
- R10: While `enable_i` is low, no branch is recorded and TOS does not move.
- R11: A port write with `wr_sel_i` = 0 sets a source word, 1 sets a target word, and 2 sets TOS from the low bits of `wr_data_i`. Any port write drops a branch event presented in the same cycle.
- R12: TOS wraps from DEPTH-1 to 0 on a push and from 0 to DEPTH-1 on a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global recording enable |
| frz_on_pmi_i | input | 1 | Freeze recording on a performance interrupt |
| frz_clr_i | input | 1 | Clear the freeze flag |
| pmi_i | input | 1 | Performance-interrupt pulse |
| sel_i | input | 10 | Filter/select word (bits 0-8 suppress, bit 9 call-stack mode) |
| br_valid_i | input | 1 | Branch event valid |
| br_from_i | input | ADDR_W | Source address |
| br_to_i | input | ADDR_W | Target address |
| br_cat_i | input | 3 | Branch category code |
| br_ring_i | input | 2 | Privilege ring of the target |
| br_mispred_i | input | 1 | Branch was mispredicted |
| br_in_tx_i | input | 1 | Branch inside a transaction |
| br_abort_i | input | 1 | Transfer caused by a transaction abort |
| wr_en_i | input | 1 | Register-port write strobe |
| wr_sel_i | input | 2 | Write target: 0 source word, 1 target word, 2 TOS |
| wr_idx_i | input | log2(DEPTH) | Entry index for a write |
| wr_data_i | input | 64 | Write data |
| rd_idx_i | input | log2(DEPTH) | Entry index for a read |
| rd_from_o | output | 64 | Source word of the indexed entry |
| rd_to_o | output | 64 | Target word of the indexed entry |
| tos_o | output | log2(DEPTH) | Top-of-stack pointer |
| frozen_o | output | 1 | Freeze flag |

## Verification
The bench builds the block with DEPTH = 8, ADDR_W = 48 and the timed target format. The shallow depth lets a run of ten branches wrap TOS past the last slot and then walk the whole history back through the index arithmetic. With 48-bit addresses, the sign extension into bits 60:48 and the cycle field in bits 63:48 can both be seen directly. Call-stack push and pop, the race between freeze and clear, and a port write that collides with a capture are each driven as a separate scenario.

// File: rtl/brr_pkg.sv
package brr_pkg;
  localparam int SEL_W  = 10;
  localparam int CAT_W  = 3;
  localparam int WORD_W = 64;
  localparam int CYC_W  = 16;
  localparam int SEL_RING0  = 0;
  localparam int SEL_RINGN  = 1;
  localparam int SEL_CAT_LO = 2;
  localparam int SEL_CAT_HI = 8;
  localparam int SEL_CSTACK = 9;

  typedef enum logic [CAT_W-1:0] {
    CAT_COND  = 3'd0,
    CAT_RCALL = 3'd1,
    CAT_ICALL = 3'd2,
    CAT_NRET  = 3'd3,
    CAT_IJMP  = 3'd4,
    CAT_RJMP  = 3'd5,
    CAT_FAR   = 3'd6,
    CAT_NONE  = 3'd7
  } br_cat_e;

  typedef enum logic [1:0] {
    WR_FROM = 2'd0,
    WR_TO   = 2'd1,
    WR_TOS  = 2'd2
  } wr_sel_e;
endpackage

// File: rtl/brr_filter.sv
module brr_filter import brr_pkg::*; (
  input  logic             valid_i,
  input  logic             active_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CAT_W-1:0] cat_i,
  input  logic [1:0]       ring_i,
  output logic             rec_o,
  output logic             pop_o
);
  logic [7:0] cat_sup_vec;
  logic       cat_sup, ring_sup, pass, cs_mode, is_call, is_ret;

  // code 7 maps to a constant suppress bit
  assign cat_sup_vec = {1'b1, sel_i[SEL_CAT_HI:SEL_CAT_LO]};
  assign cat_sup     = cat_sup_vec[cat_i];
  assign ring_sup    = (ring_i == 2'd0) ? sel_i[SEL_RING0] : sel_i[SEL_RINGN];
  assign pass        = valid_i && active_i && !cat_sup && !ring_sup;
  assign cs_mode     = sel_i[SEL_CSTACK];
  assign is_call     = (cat_i == CAT_RCALL) || (cat_i == CAT_ICALL);
  assign is_ret      = (cat_i == CAT_NRET);
  assign rec_o       = pass && (!cs_mode || is_call);
  assign pop_o       = pass && cs_mode && is_ret;
endmodule

// File: rtl/brr_freeze.sv
module brr_freeze (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frz_en_i,
  input  logic cs_mode_i,
  input  logic pmi_i,
  input  logic clr_i,
  output logic frozen_o
);
  logic set;
  assign set = pmi_i && frz_en_i && !cs_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frozen_o <= 1'b0;
    else if (set)   frozen_o <= 1'b1;
    else if (clr_i) frozen_o <= 1'b0;
  end
endmodule

// File: rtl/brr_cyc.sv
module brr_cyc #(
  parameter int CYC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rec_i,
  output logic [CYC_W-1:0] cyc_o
);
  localparam logic [CYC_W-1:0] CYC_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cyc_o <= '0;
    else if (rec_i)             cyc_o <= CYC_W'(1);
    else if (cyc_o != CYC_MAX)  cyc_o <= cyc_o + CYC_W'(1);
  end
endmodule

// File: rtl/brr_store.sv
module brr_store import brr_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_i,
  input  logic              pop_i,
  input  logic [WORD_W-1:0] rec_from_i,
  input  logic [WORD_W-1:0] rec_to_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_from_o,
  output logic [WORD_W-1:0] rd_to_o,
  output logic [IDX_W-1:0]  tos_o
);
  logic [WORD_W-1:0] from_arr [DEPTH];
  logic [WORD_W-1:0] to_arr   [DEPTH];
  logic [IDX_W-1:0]  tos_nxt;
  logic              wr_from, wr_to, wr_tos;

  assign wr_from = wr_en_i && (wr_sel_i == WR_FROM);
  assign wr_to   = wr_en_i && (wr_sel_i == WR_TO);
  assign wr_tos  = wr_en_i && (wr_sel_i == WR_TOS);
  assign tos_nxt = tos_o + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tos_o <= '0;
    else if (wr_tos) tos_o <= wr_data_i[IDX_W-1:0];
    else if (rec_i)  tos_o <= tos_nxt;
    else if (pop_i)  tos_o <= tos_o - IDX_W'(1);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [WORD_W-1:0] f_q, t_q;
    logic              hit_wr, hit_rec;
    assign hit_wr  = (wr_idx_i == IDX_W'(e));
    assign hit_rec = rec_i && (tos_nxt == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        f_q <= '0;
        t_q <= '0;
      end else begin
        if (wr_from && hit_wr) f_q <= wr_data_i;
        else if (hit_rec)      f_q <= rec_from_i;
        if (wr_to && hit_wr)   t_q <= wr_data_i;
        else if (hit_rec)      t_q <= rec_to_i;
      end
    end
    assign from_arr[e] = f_q;
    assign to_arr[e]   = t_q;
  end

  assign rd_from_o = from_arr[rd_idx_i];
  assign rd_to_o   = to_arr[rd_idx_i];
endmodule

// File: rtl/brr_ring.sv
module brr_ring import brr_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 48,
  parameter bit TIMED  = 1'b1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              frz_on_pmi_i,
  input  logic              frz_clr_i,
  input  logic              pmi_i,
  input  logic [9:0]        sel_i,
  input  logic              br_valid_i,
  input  logic [ADDR_W-1:0] br_from_i,
  input  logic [ADDR_W-1:0] br_to_i,
  input  logic [2:0]        br_cat_i,
  input  logic [1:0]        br_ring_i,
  input  logic              br_mispred_i,
  input  logic              br_in_tx_i,
  input  logic              br_abort_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [63:0]       wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [63:0]       rd_from_o,
  output logic [63:0]       rd_to_o,
  output logic [IDX_W-1:0]  tos_o,
  output logic              frozen_o
);
  localparam int FROM_A_W = WORD_W - 3;

  logic              active, rec, pop;
  logic [WORD_W-1:0] rec_from, rec_to;

  // a port write owns the cycle
  assign active = enable_i && !frozen_o && !wr_en_i;

  brr_filter u_filter (
    .valid_i (br_valid_i),
    .active_i(active),
    .sel_i   (sel_i),
    .cat_i   (br_cat_i),
    .ring_i  (br_ring_i),
    .rec_o   (rec),
    .pop_o   (pop)
  );

  brr_freeze u_freeze (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frz_en_i (frz_on_pmi_i),
    .cs_mode_i(sel_i[SEL_CSTACK]),
    .pmi_i    (pmi_i),
    .clr_i    (frz_clr_i),
    .frozen_o (frozen_o)
  );

  assign rec_from = {br_mispred_i, br_in_tx_i, br_abort_i,
                     {(FROM_A_W-ADDR_W){br_from_i[ADDR_W-1]}}, br_from_i};

  if (TIMED) begin : g_timed
    logic [CYC_W-1:0] cyc;
    brr_cyc #(.CYC_W(CYC_W)) u_cyc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rec_i (rec),
      .cyc_o (cyc)
    );
    assign rec_to = {cyc, br_to_i[WORD_W-CYC_W-1:0]};
  end else begin : g_plain
    assign rec_to = {{(WORD_W-ADDR_W){br_to_i[ADDR_W-1]}}, br_to_i};
  end

  brr_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rec_i     (rec),
    .pop_i     (pop),
    .rec_from_i(rec_from),
    .rec_to_i  (rec_to),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (rd_idx_i),
    .rd_from_o (rd_from_o),
    .rd_to_o   (rd_to_o),
    .tos_o     (tos_o)
  );
endmodule

// File: rtl/brr_ring_chk.sv
module brr_ring_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             sel_cs_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [IDX_W-1:0] wr_tos_val_i,
  input logic [IDX_W-1:0] tos_o,
  input logic             frozen_o,
  input logic             rec_i,
  input logic             pop_i
);
  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> tos_o == IDX_W'($past(tos_o) + 1'b1)); // R2

  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> tos_o == IDX_W'($past(tos_o) - 1'b1)); // R7

  AST_TOS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd2) |=> tos_o == $past(wr_tos_val_i)); // R11

  AST_FROZEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> !rec_i && !pop_i); // R8

  AST_CS_NO_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_cs_i && !frozen_o) |=> !frozen_o); // R9

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !rec_i && !pop_i); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_i && !pop_i && !wr_en_i) |=> $stable(tos_o)); // R2
endmodule

bind brr_ring brr_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .sel_cs_i    (sel_i[9]),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_tos_val_i(wr_data_i[IDX_W-1:0]),
  .tos_o       (tos_o),
  .frozen_o    (frozen_o),
  .rec_i       (rec),
  .pop_i       (pop)
);

// File: tb/brr_ring_tb.sv
module brr_ring_tb;
  localparam int DEPTH = 8;
  localparam int AW    = 48;
  localparam int IW    = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enable_i = 1'b0, frz_on_pmi_i = 1'b0, frz_clr_i = 1'b0, pmi_i = 1'b0;
  logic [9:0]    sel_i = '0;
  logic          br_valid_i = 1'b0;
  logic [AW-1:0] br_from_i = '0, br_to_i = '0;
  logic [2:0]    br_cat_i = '0;
  logic [1:0]    br_ring_i = '0;
  logic          br_mispred_i = 1'b0, br_in_tx_i = 1'b0, br_abort_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_sel_i = '0;
  logic [IW-1:0] wr_idx_i = '0, rd_idx_i = '0;
  logic [63:0]   wr_data_i = '0;
  logic [63:0]   rd_from_o, rd_to_o;
  logic [IW-1:0] tos_o;
  logic          frozen_o;

  always #4 clk_i = ~clk_i;

  brr_ring #(.DEPTH(DEPTH), .ADDR_W(AW), .TIMED(1'b1)) u_dut (.*);

  int checks = 0, errors = 0, etos = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_tos(input string req);
    chk(req, 64'(tos_o), 64'(etos & (DEPTH-1)));
  endtask

  function automatic logic [63:0] xfrom(input logic [AW-1:0] f, input logic m, x, a);
    return {m, x, a, {13{f[AW-1]}}, f};
  endfunction

  task automatic br(input logic [AW-1:0] f, t, input int cat, input int ring,
                    input logic m = 1'b0, x = 1'b0, a = 1'b0);
    br_valid_i = 1'b1; br_from_i = f; br_to_i = t;
    br_cat_i = 3'(cat); br_ring_i = 2'(ring);
    br_mispred_i = m; br_in_tx_i = x; br_abort_i = a;
    @(negedge clk_i);
    br_valid_i = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [63:0] fw, output logic [63:0] tw);
    rd_idx_i = IW'(idx);
    #1;
    fw = rd_from_o;
    tw = rd_to_o;
  endtask

  task automatic t_reset;
    logic [63:0] fw, tw;
    chk("R1 tos", 64'(tos_o), 64'd0);
    chk("R1 frozen", 64'(frozen_o), 64'd0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, fw, tw);
      chk("R1 from", fw, 64'd0);
      chk("R1 to", tw, 64'd0);
    end
  endtask

  task automatic t_format;
    logic [63:0] fw, tw;
    br(48'h8000_0000_1234, 48'h0000_0000_5678, 0, 3, 1'b1, 1'b0, 1'b1);
    etos++;
    chk_tos("R2 advance");
    rd(etos & (DEPTH-1), fw, tw);
    chk("R3 from word", fw, xfrom(48'h8000_0000_1234, 1'b1, 1'b0, 1'b1));
    chk("R4 to addr", 64'(tw[47:0]), 64'h5678);
    br(48'h0000_0000_0100, 48'hFFFF_0000_0200, 0, 3, 1'b0, 1'b1, 1'b0);
    etos++;
    rd(etos & (DEPTH-1), fw, tw);
    chk("R3 flags tx", fw, xfrom(48'h0000_0000_0100, 1'b0, 1'b1, 1'b0));
    chk("R4 cycles back-to-back", 64'(tw[63:48]), 64'd1);
    repeat (3) @(negedge clk_i);
    br(48'h300, 48'h400, 0, 3);
    etos++;
    rd(etos & (DEPTH-1), fw, tw);
    chk("R4 cycles gap", 64'(tw[63:48]), 64'd4);
  endtask

  task automatic t_history;
    logic [63:0] fw, tw;
    for (int k = 0; k < DEPTH + 2; k++) begin
      br(48'h1000 + 48'(k), 48'h2000 + 48'(k), 0, 3);
      etos++;
      if ((etos & (DEPTH-1)) == 0) chk_tos("R12 wrap to zero");
    end
    chk_tos("R2 tos after run");
    for (int i = 0; i < DEPTH; i++) begin
      rd((etos - i) & (DEPTH-1), fw, tw);
      chk("R2 history", 64'(fw[47:0]), 64'h1000 + 64'(DEPTH + 1 - i));
    end
  endtask

  task automatic t_category;
    for (int c = 0; c < 7; c++) begin
      sel_i = 10'(1 << (2 + c));
      br(48'h500, 48'h600, c, 3);
      chk_tos("R5 suppressed");
      br(48'h500, 48'h600, (c + 1) % 7, 3);
      etos++;
      chk_tos("R5 other category passes");
    end
    sel_i = '0;
    br(48'h500, 48'h600, 7, 3);
    chk_tos("R5 code 7 dropped");
  endtask

  task automatic t_ring;
    sel_i = 10'h001;
    br(48'h10, 48'h20, 0, 0);
    chk_tos("R6 ring0 suppressed");
    br(48'h10, 48'h20, 0, 3);
    etos++;
    chk_tos("R6 ring3 passes");
    sel_i = 10'h002;
    br(48'h10, 48'h20, 0, 2);
    chk_tos("R6 ring2 suppressed");
    br(48'h10, 48'h20, 0, 0);
    etos++;
    chk_tos("R6 ring0 passes");
    sel_i = '0;
  endtask

  task automatic t_callstack;
    logic [63:0] fw, tw;
    sel_i = 10'h200;
    if ((etos & (DEPTH-1)) != 0) begin
      wr_en_i = 1'b1; wr_sel_i = 2'd2; wr_data_i = 64'd0;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      etos = 0;
    end
    br(48'hA1, 48'hB1, 1, 3);
    etos++;
    chk_tos("R7 call push");
    br(48'hA2, 48'hB2, 0, 3);
    chk_tos("R7 cond ignored");
    br(48'hA3, 48'hB3, 2, 3);
    etos++;
    chk_tos("R7 indirect call push");
    br(48'hA4, 48'hB4, 3, 3);
    etos--;
    chk_tos("R7 return pop");
    rd(etos & (DEPTH-1), fw, tw);
    chk("R7 entry at tos after pop", 64'(fw[47:0]), 64'hA1);
    br(48'hA5, 48'hB5, 3, 3);
    etos--;
    chk_tos("R7 second pop");
    br(48'hA6, 48'hB6, 3, 3);
    etos--;
    chk_tos("R12 pop wraps to top");
    sel_i = 10'h208;
    br(48'hA7, 48'hB7, 1, 3);
    chk_tos("R7 suppressed call not pushed");
    br(48'hA8, 48'hB8, 6, 3);
    chk_tos("R7 far not recorded");
    sel_i = '0;
  endtask

  task automatic t_freeze;
    frz_on_pmi_i = 1'b1;
    pmi_i = 1'b1;
    br(48'h70, 48'h80, 0, 3);
    pmi_i = 1'b0;
    etos++;
    chk_tos("R8 branch in pulse cycle kept");
    chk("R8 frozen set", 64'(frozen_o), 64'd1);
    br(48'h71, 48'h81, 0, 3);
    chk_tos("R8 no capture while frozen");
    pmi_i = 1'b1; frz_clr_i = 1'b1;
    @(negedge clk_i);
    pmi_i = 1'b0; frz_clr_i = 1'b0;
    chk("R8 pulse beats clear", 64'(frozen_o), 64'd1);
    frz_clr_i = 1'b1;
    @(negedge clk_i);
    frz_clr_i = 1'b0;
    chk("R8 cleared", 64'(frozen_o), 64'd0);
    br(48'h72, 48'h82, 0, 3);
    etos++;
    chk_tos("R8 capture resumes");
  endtask

  task automatic t_cs_freeze;
    sel_i = 10'h200;
    pmi_i = 1'b1;
    @(negedge clk_i);
    pmi_i = 1'b0;
    chk("R9 no freeze in call-stack mode", 64'(frozen_o), 64'd0);
    br(48'h90, 48'h91, 1, 3);
    etos++;
    chk_tos("R9 call still pushed");
    sel_i = '0;
    frz_on_pmi_i = 1'b0;
  endtask

  task automatic t_disable;
    enable_i = 1'b0;
    br(48'h33, 48'h44, 0, 3);
    chk_tos("R10 disabled no capture");
    enable_i = 1'b1;
  endtask

  task automatic t_regwrite;
    logic [63:0] fw0, tw0, fw, tw;
    int nxt;
    nxt = (etos + 1) & (DEPTH-1);
    rd(nxt, fw0, tw0);
    wr_en_i = 1'b1; wr_sel_i = 2'd2; wr_data_i = 64'd5;
    br(48'hEE, 48'hFF, 0, 3);
    wr_en_i = 1'b0;
    etos = 5;
    chk_tos("R11 tos written");
    rd(nxt, fw, tw);
    chk("R11 capture dropped", fw, fw0);
    wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_idx_i = 3'd2; wr_data_i = 64'hDEAD_BEEF_0000_1111;
    @(negedge clk_i);
    wr_sel_i = 2'd1; wr_data_i = 64'h0123_4567_89AB_CDEF;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    rd(2, fw, tw);
    chk("R11 from write", fw, 64'hDEAD_BEEF_0000_1111);
    chk("R11 to write", tw, 64'h0123_4567_89AB_CDEF);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    enable_i = 1'b1;
    t_format;
    t_history;
    t_category;
    t_ring;
    t_callstack;
    t_freeze;
    t_cs_freeze;
    t_disable;
    t_regwrite;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule